// File: doc/BRIEF.md
# Low-Power Lane Turnaround Controller

This block sequences the hand-over of a bidirectional low-power data lane between the two ends of a link. It starts out as the lane's owner and drives the stop state. On a give-away request it plays out the turnaround request pattern and holds the bridge state. It then lets go of the lines and waits for the far end to confirm with its own bridge and LP-10. In the other direction it sits as a receiver. When it sees the line fall from LP-11 to LP-10, it waits a short settling window, drives the bridge state for the take-over interval, and walks the line back through LP-10 to LP-11 as the new owner.

All step lengths are whole multiples of one programmable low-power period, `lpxCycles`, counted in clock cycles. When the far end fails to show an awaited line state within the programmable `toCycles` window, the block flags an error and takes the lane back in the stop state.

Line states are two-bit codes {positive wire, negative wire}: LP-11 = 2'b11, LP-10 = 2'b10, LP-00 = 2'b00.

Top module: `lp_turnaround`

## Requirements
- R1: After reset, driveEn=1, lineOut=2'b11 (LP-11), dirRx=0, done=0 and err=0.
- R2: A giveReq sampled while owning and idle starts the request pattern on the next cycle. The pattern is LP-11, LP-10, LP-00 and LP-10, one LPX each, followed by LP-00 held for four LPX.
- R3: When the four-LPX bridge ends, driveEn falls to 0 and dirRx rises to 1. Whenever driveEn is 0, lineOut reads 2'b11.
- R4: After release, the block waits for LP-00 and then for LP-10 on lineIn. done pulses for one cycle, one cycle after LP-10 is sampled, and the block stays receiving.
- R5: Each of the two waits after release lasts at most toCycles cycles (0 counts as 1). If the awaited state is not sampled in that window, err pulses for one cycle and the block is owning again with LP-11 driven (driveEn=1, dirRx=0).
- R6: While receiving and idle, a sampled LP-10 whose previous sample was LP-11 starts a take-over. The block first waits, undriven, for one LPX when sureLong=0 or for two LPX when sureLong=1.
- R7: The take-over then drives LP-00 for five LPX with dirRx=0, and LP-10 for one LPX. It then returns to LP-11 with a one-cycle done pulse.
- R8: giveReq has no effect unless the block is owning and idle. Line activity on lineIn has no effect while the block owns the lane.
- R9: lpxCycles=0 behaves as lpxCycles=1.
- R10: done and err are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| lpxCycles | input | LPX_W | Low-power period length in cycles |
| toCycles | input | TO_W | Wait window for far-end responses in cycles |
| sureLong | input | 1 | Take-over settling wait: 0 = one LPX, 1 = two LPX |
| giveReq | input | 1 | Request to hand the lane to the far end |
| lineIn | input | 2 | Sampled line state {p, n} |
| lineOut | output | 2 | Driven line state {p, n} |
| driveEn | output | 1 | Line drivers enabled |
| dirRx | output | 1 | 1 while the far end owns the lane |
| done | output | 1 | Turnaround completed pulse |
| err | output | 1 | Response timeout pulse |

## Verification
The control state is registered, and the line outputs decode straight from it. A step that begins at a sampling edge is therefore visible at the following falling edge. The bench counts falling edges from the edge that sampled giveReq or the LP-11 to LP-10 fall, and predicts every output at each offset from the LPX multiples. A done pulse is due exactly one falling edge after the far end's LP-10 is driven. An err pulse is due toCycles falling edges after the wait began, or toCycles+1 when the LP-00 wait was satisfied first. The bench samples exactly there and checks the neighbouring cycles for the absence of the pulse.

// File: rtl/lp_turnaround_pkg.sv
package lp_turnaround_pkg;

  localparam logic [1:0] LINE_00 = 2'b00;
  localparam logic [1:0] LINE_10 = 2'b10;
  localparam logic [1:0] LINE_11 = 2'b11;

  // strobes from control to the timing datapath
  typedef struct packed {
    logic       tmrLoad;   // reload step timer with mult * LPX
    logic [2:0] tmrMult;   // number of LPX periods for the new step
    logic       toLoad;    // reload the response wait window
  } taStrb_t;

  typedef enum logic [3:0] {
    S_TXIDLE, S_RQ11, S_RQ10A, S_RQ00A, S_RQ10B, S_GOBR,
    S_W00, S_W10, S_RXIDLE, S_SURE, S_GETBR, S_GET10
  } taState_e;

endpackage

// File: rtl/lp_ta_datapath.sv
module lp_ta_datapath
  import lp_turnaround_pkg::*;
#(
  parameter int LPX_W = 8,
  parameter int TO_W  = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LPX_W-1:0] lpxCycles,
  input  logic [TO_W-1:0]  toCycles,
  input  logic [1:0]       lineIn,
  input  taStrb_t          strb,
  output logic             tmrDone,
  output logic             toDone,
  output logic             takeEdge
);

  localparam int TMR_W = LPX_W + 3;

  logic [TMR_W-1:0] tmr, lpxEff, tmrLoadVal;
  logic [TO_W-1:0]  toCnt, toLoadVal;
  logic [1:0]       lastLine;

  // a zero period is treated as one cycle
  assign lpxEff     = (lpxCycles == '0) ? TMR_W'(1) : TMR_W'(lpxCycles);
  assign tmrLoadVal = lpxEff * TMR_W'(strb.tmrMult) - TMR_W'(1);
  assign toLoadVal  = (toCycles == '0) ? '0 : toCycles - TO_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmr      <= '0;
      toCnt    <= '0;
      lastLine <= LINE_11;
    end else begin
      lastLine <= lineIn;
      if (strb.tmrLoad)   tmr <= tmrLoadVal;
      else if (tmr != '0) tmr <= tmr - TMR_W'(1);
      if (strb.toLoad)      toCnt <= toLoadVal;
      else if (toCnt != '0) toCnt <= toCnt - TO_W'(1);
    end
  end

  assign tmrDone  = (tmr == '0);
  assign toDone   = (toCnt == '0);
  assign takeEdge = (lineIn == LINE_10) && (lastLine == LINE_11);

  // R2
  tmr_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(strb.tmrLoad) && $past(tmr) != '0) |-> tmr == $past(tmr) - TMR_W'(1));

  // R5
  to_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(strb.toLoad) && $past(toCnt) != '0) |-> toCnt == $past(toCnt) - TO_W'(1));

endmodule

// File: rtl/lp_ta_ctrl.sv
module lp_ta_ctrl
  import lp_turnaround_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       giveReq,
  input  logic       sureLong,
  input  logic [1:0] lineIn,
  input  logic       tmrDone,
  input  logic       toDone,
  input  logic       takeEdge,
  output taStrb_t    strb,
  output logic [1:0] lineOut,
  output logic       driveEn,
  output logic       dirRx,
  output logic       done,
  output logic       err
);

  taState_e st, stNext;
  logic     doneNext, errNext;

  always_comb begin
    stNext   = st;
    strb     = '0;
    doneNext = 1'b0;
    errNext  = 1'b0;
    unique case (st)
      S_TXIDLE: if (giveReq) begin
        stNext = S_RQ11; strb.tmrLoad = 1'b1; strb.tmrMult = 3'd1;
      end
      S_RQ11: if (tmrDone) begin
        stNext = S_RQ10A; strb.tmrLoad = 1'b1; strb.tmrMult = 3'd1;
      end
      S_RQ10A: if (tmrDone) begin
        stNext = S_RQ00A; strb.tmrLoad = 1'b1; strb.tmrMult = 3'd1;
      end
      S_RQ00A: if (tmrDone) begin
        stNext = S_RQ10B; strb.tmrLoad = 1'b1; strb.tmrMult = 3'd1;
      end
      S_RQ10B: if (tmrDone) begin
        stNext = S_GOBR; strb.tmrLoad = 1'b1; strb.tmrMult = 3'd4;
      end
      S_GOBR: if (tmrDone) begin
        stNext = S_W00; strb.toLoad = 1'b1;
      end
      S_W00: begin
        if (lineIn == LINE_00) begin
          stNext = S_W10; strb.toLoad = 1'b1;
        end else if (toDone) begin
          stNext = S_TXIDLE; errNext = 1'b1;
        end
      end
      S_W10: begin
        if (lineIn == LINE_10) begin
          stNext = S_RXIDLE; doneNext = 1'b1;
        end else if (toDone) begin
          stNext = S_TXIDLE; errNext = 1'b1;
        end
      end
      S_RXIDLE: if (takeEdge) begin
        stNext = S_SURE; strb.tmrLoad = 1'b1;
        strb.tmrMult = sureLong ? 3'd2 : 3'd1;
      end
      S_SURE: if (tmrDone) begin
        stNext = S_GETBR; strb.tmrLoad = 1'b1; strb.tmrMult = 3'd5;
      end
      S_GETBR: if (tmrDone) begin
        stNext = S_GET10; strb.tmrLoad = 1'b1; strb.tmrMult = 3'd1;
      end
      S_GET10: if (tmrDone) begin
        stNext = S_TXIDLE; doneNext = 1'b1;
      end
      default: stNext = S_TXIDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st   <= S_TXIDLE;
      done <= 1'b0;
      err  <= 1'b0;
    end else begin
      st   <= stNext;
      done <= doneNext;
      err  <= errNext;
    end
  end

  always_comb begin
    lineOut = LINE_11;
    driveEn = 1'b0;
    dirRx   = 1'b0;
    case (st)
      S_TXIDLE, S_RQ11:           driveEn = 1'b1;
      S_RQ10A, S_RQ10B, S_GET10:  begin driveEn = 1'b1; lineOut = LINE_10; end
      S_RQ00A, S_GOBR, S_GETBR:   begin driveEn = 1'b1; lineOut = LINE_00; end
      S_W00, S_W10, S_RXIDLE, S_SURE: dirRx = 1'b1;
      default: ;
    endcase
  end

  // R10
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rstN) !(done && err));

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN) done |=> !done);

  // R5
  err_home_chk: assert property (@(posedge clk) disable iff (!rstN)
    err |-> (driveEn && !dirRx && lineOut == LINE_11));

  // R3
  rx_nodrive_chk: assert property (@(posedge clk) disable iff (!rstN)
    dirRx |-> (!driveEn && lineOut == LINE_11));

  // R4
  done_rx_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && dirRx) |-> $past(lineIn) == LINE_10);

  // R7
  done_tx_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !dirRx) |-> $past(lineOut) == LINE_10);

endmodule

// File: rtl/lp_turnaround.sv
module lp_turnaround
  import lp_turnaround_pkg::*;
#(
  parameter int LPX_W = 8,
  parameter int TO_W  = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LPX_W-1:0] lpxCycles,
  input  logic [TO_W-1:0]  toCycles,
  input  logic             sureLong,
  input  logic             giveReq,
  input  logic [1:0]       lineIn,
  output logic [1:0]       lineOut,
  output logic             driveEn,
  output logic             dirRx,
  output logic             done,
  output logic             err
);

  taStrb_t strb;
  logic    tmrDone, toDone, takeEdge;

  lp_ta_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .giveReq(giveReq), .sureLong(sureLong),
    .lineIn(lineIn), .tmrDone(tmrDone), .toDone(toDone), .takeEdge(takeEdge),
    .strb(strb), .lineOut(lineOut), .driveEn(driveEn), .dirRx(dirRx),
    .done(done), .err(err)
  );

  lp_ta_datapath #(.LPX_W(LPX_W), .TO_W(TO_W)) dp_i (
    .clk(clk), .rstN(rstN), .lpxCycles(lpxCycles), .toCycles(toCycles),
    .lineIn(lineIn), .strb(strb), .tmrDone(tmrDone), .toDone(toDone),
    .takeEdge(takeEdge)
  );

endmodule

// File: tb/lp_turnaround_tb_top.sv
`timescale 1ns/1ps
module lp_turnaround_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  lpxCycles = 8'd2;
  logic [11:0] toCycles = 12'd10;
  logic        sureLong = 1'b0;
  logic        giveReq = 1'b0;
  logic [1:0]  lineIn = 2'b11;
  logic [1:0]  lineOut;
  logic        driveEn, dirRx, done, err;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  lp_turnaround dut_i (
    .clk(clk), .rstN(rstN), .lpxCycles(lpxCycles), .toCycles(toCycles),
    .sureLong(sureLong), .giveReq(giveReq), .lineIn(lineIn),
    .lineOut(lineOut), .driveEn(driveEn), .dirRx(dirRx), .done(done), .err(err)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int obs();
    return {driveEn, lineOut, dirRx};
  endfunction

  // expected {driveEn, lineOut, dirRx} n falling edges after giveReq sampled
  function automatic int giveExp(int n, int l);
    if (n < l)     return {1'b1, 2'b11, 1'b0};
    if (n < 2*l)   return {1'b1, 2'b10, 1'b0};
    if (n < 3*l)   return {1'b1, 2'b00, 1'b0};
    if (n < 4*l)   return {1'b1, 2'b10, 1'b0};
    if (n < 8*l)   return {1'b1, 2'b00, 1'b0};
    return {1'b0, 2'b11, 1'b1};
  endfunction

  // expected outputs n falling edges after the take-over trigger
  function automatic int takeExp(int n, int l, int s);
    if (n < s*l)       return {1'b0, 2'b11, 1'b1};
    if (n < s*l + 5*l) return {1'b1, 2'b00, 1'b0};
    if (n < s*l + 6*l) return {1'b1, 2'b10, 1'b0};
    return {1'b1, 2'b11, 1'b0};
  endfunction

  // mode 0: success, 1: no LP-00, 2: LP-00 but no LP-10
  task automatic runGive(input int l, input int to, input int mode, input int d00, input int k);
    lineIn  = 2'b11;
    giveReq = 1'b1;
    @(negedge clk);
    giveReq = 1'b0;
    for (int n = 0; n < 8*l; n++) begin
      chk("R2 give sequence", obs(), giveExp(n, l));
      @(negedge clk);
    end
    chk("R3 released", obs(), giveExp(8*l, l));
    if (mode == 0) begin
      for (int i = 0; i < d00; i++) begin
        chk("R4 no early err", err, 0);
        @(negedge clk);
      end
      lineIn = 2'b00;
      for (int i = 0; i < k; i++) @(negedge clk);
      chk("R4 no early done", done, 0);
      lineIn = 2'b10;
      @(negedge clk);
      chk("R4 done pulse", done, 1);
      chk("R4 still receiving", obs(), {1'b0, 2'b11, 1'b1});
      @(negedge clk);
      chk("R10 done single", done, 0);
    end else begin
      int errOff = (mode == 1) ? to : to + 1;
      if (mode == 2) lineIn = 2'b00;
      for (int i = 0; i <= errOff; i++) begin
        chk("R5 err timing", err, (i == errOff) ? 1 : 0);
        if (i < errOff) @(negedge clk);
      end
      chk("R5 back to owning", obs(), {1'b1, 2'b11, 1'b0});
      chk("R10 no done with err", done, 0);
      @(negedge clk);
      chk("R10 err single", err, 0);
    end
  endtask

  task automatic runTake(input int l, input bit sl);
    int s = sl ? 2 : 1;
    sureLong = sl;
    chk("R6 receiving idle", obs(), {1'b0, 2'b11, 1'b1});
    lineIn = 2'b11;
    @(negedge clk);
    chk("R6 no trigger on LP-11", obs(), {1'b0, 2'b11, 1'b1});
    lineIn = 2'b10;
    @(negedge clk);
    for (int n = 0; n <= s*l + 6*l; n++) begin
      chk("R7 take sequence", obs(), takeExp(n, l, s));
      chk("R7 done timing", done, (n == s*l + 6*l) ? 1 : 0);
      @(negedge clk);
    end
    lineIn = 2'b11;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", obs(), {1'b1, 2'b11, 1'b0});
    chk("R1 reset done", done, 0);
    chk("R1 reset err", err, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R8: line activity while owning
    lineIn = 2'b11; @(negedge clk);
    lineIn = 2'b10; @(negedge clk); @(negedge clk);
    chk("R8 line ignored while owning", obs(), {1'b1, 2'b11, 1'b0});

    // directed: success then take-over
    lpxCycles = 8'd2; toCycles = 12'd10;
    runGive(2, 10, 0, 0, 1);
    // R8: giveReq while receiving
    giveReq = 1'b1; @(negedge clk); giveReq = 1'b0;
    for (int i = 0; i < 3; i++) begin
      chk("R8 giveReq ignored in rx", obs(), {1'b0, 2'b11, 1'b1});
      @(negedge clk);
    end
    runTake(2, 1'b0);

    // R8: giveReq during sequence has no extra effect
    lpxCycles = 8'd3;
    giveReq = 1'b1; @(negedge clk);
    for (int n = 0; n < 24; n++) begin
      chk("R8 giveReq held", obs(), giveExp(n, 3));
      @(negedge clk);
    end
    giveReq = 1'b0;
    lineIn = 2'b00; @(negedge clk); lineIn = 2'b10; @(negedge clk);
    chk("R4 done after held req", done, 1);
    runTake(3, 1'b1);

    // R9: zero period acts as one
    lpxCycles = 8'd0; toCycles = 12'd5;
    runGive(1, 5, 0, 4, 5);
    runTake(1, 1'b1);

    // R5 corners: minimum window, both waits
    lpxCycles = 8'd1; toCycles = 12'd1;
    runGive(1, 1, 1, 0, 0);
    runGive(1, 1, 2, 0, 0);
    toCycles = 12'd0;
    runGive(1, 1, 1, 0, 0);

    // constrained random rounds
    for (int it = 0; it < 16; it++) begin
      int l    = $urandom_range(1, 5);
      int to   = $urandom_range(4, 30);
      int mode = $urandom_range(0, 3);
      lpxCycles = 8'(l);
      toCycles  = 12'(to);
      if (mode <= 1) begin
        runGive(l, to, 0, $urandom_range(0, to - 1), $urandom_range(1, to));
        runTake(l, 1'($urandom_range(0, 1)));
      end else begin
        runGive(l, to, mode - 1, 0, 0);
      end
    end

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule